// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block lets a controller read and write a small configuration register file over a half-duplex serial bus. The bus has three wires: an active-low frame select (`csb`), a serial clock (`sclk`) and one data line that carries traffic in both directions. The data line's pad is split here into `sdio_in`, `sdio_out` and an output enable, `sdio_oe`. A separate active-low line, `bus_en_n`, must be low for the block to respond at all.

Each frame holds sixteen bits. First comes a direction flag, then a 7-bit register address, then one data byte. For a write, the controller drives all sixteen bits. For a read, the controller drives only the first eight. The block then takes over the line and shifts the addressed byte back.

The register file holds 48 bytes. All of them are presented in parallel on `cfg_regs`, so downstream logic can use the configuration directly.

All bus inputs are resynchronised to `clk`, which must run well above the serial clock. Every bus edge therefore takes effect within four `clk` cycles.

Top module: `spi3w_regslave`

## Requirements
- R1: While `bus_en_n` is high, the block ignores the bus. No register changes and `sdio_oe` stays low, even if a complete frame is clocked in.
- R2: A falling `csb` starts a frame and a rising `csb` ends it. Rising `sclk` edges after the sixteenth in a frame are ignored, so a frame never affects more than one register.
- R3: `sdio_in` is sampled on rising `sclk` edges. The first bit is the direction flag (1 = read, 0 = write). The next seven bits are the register address, most significant bit first.
- R4: For a write, the byte in bits 9 to 16 (MSB first) is stored in the addressed register when the sixteenth rising edge arrives. Register n appears on `cfg_regs[8n+7:8n]`.
- R5: For a read, `sdio_oe` rises after the eighth falling `sclk` edge. `sdio_out` then carries the addressed byte MSB first, changing only after falling edges, so the controller samples it on rising edges 9 to 16.
- R6: `sdio_oe` is low throughout write frames and during every frame's first eight bits. It drops within four `clk` cycles of `csb` rising.
- R7: A write frame that ends (by `csb` rising) before its sixteenth rising edge changes no register.
- R8: Addresses 0x30 to 0x7F are outside the file. Writes to them change no register, and reads from them return 0x00.
- R9: After reset, every register reads 0x00 and `sdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_n | input | 1 | Active-low interface enable, idles high |
| csb | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the controller |
| sdio_in | input | 1 | Data line as seen at the pad input |
| sdio_out | output | 1 | Data driven onto the line during reads |
| sdio_oe | output | 1 | Pad output enable for the data line |
| cfg_regs | output | 384 | All 48 register bytes, register n at bits 8n+7:8n |

## Verification
The bench uses data bytes 0x80 and 0x01 and addresses whose bit-reversed form is also a legal address. These separate correct MSB-first shifting from a reversed or misaligned one, on both the address and the data.

The remaining directed cases each probe one boundary:
- the last implemented address and the first unimplemented one,
- a write cut one edge short,
- a write with two surplus clocks,
- a full frame sent while the enable line is high.

A seeded random mix of reads, writes, truncations and disabled frames then runs against a byte-array model. After every frame the bench compares the whole parallel register image with the model. This catches writes that land in the wrong register or that should have been discarded.

During reads, the bench drives random levels on `sdio_in` in the data phase. A slave that kept sampling its input there would be caught.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  // Direction flag carried in the first bit of every frame.
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

endpackage

// File: rtl/spi3w_insync.sv
// Multi-bit synchroniser with a history stage for edge detection.
module spi3w_insync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] chain_q [DEPTH];
  logic [W-1:0] chain_d [DEPTH];

  always_comb begin
    chain_d[0] = d_i;
    for (int s = 1; s < DEPTH; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/spi3w_regfile.sv
// Configuration byte store: one write port, one read port, parallel image.
module spi3w_regfile #(
  parameter int NREG = 48,
  parameter int AW   = 7,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NREG*DW-1:0] regs_o
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(NREG - 1);

  logic [DW-1:0] mem_q [NREG];
  logic [NREG-1:0] sel;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      assign sel[i] = wr_en_i && (wr_addr_i == AW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mem_q[i] <= '0;
        else if (sel[i]) mem_q[i] <= wr_data_i;
      end

      assign regs_o[i*DW +: DW] = mem_q[i];
    end
  endgenerate

  // Unimplemented addresses match no entry and therefore read as zero.
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr_i == AW'(i)) rd_data_o = mem_q[i];
    end
  end

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(regs_o)) else $error("register changed without write"); // R4

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_addr_i > LAST_ADDR)) |=> $stable(regs_o)) else $error("out-of-range write landed"); // R8

  AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)) else $error("write hit several registers"); // R2

endmodule

// File: rtl/spi3w_frame.sv
// Frame sequencer: bit counting, header capture, write strobe, read turnaround.
module spi3w_frame
  import spi3w_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          oe_o
);

  localparam int HDR = 1 + AW;
  localparam int FRM = HDR + DW;
  localparam int CW  = $clog2(FRM + 1);
  localparam int RXW = FRM - 1;

  localparam logic [CW-1:0] C_HDR  = CW'(HDR);
  localparam logic [CW-1:0] C_FRM  = CW'(FRM);
  localparam logic [CW-1:0] C_LAST = CW'(FRM - 1);

  logic [CW-1:0]  cnt_q,  cnt_d;
  logic [RXW-1:0] rx_q,   rx_d;
  logic [DW-1:0]  tx_q,   tx_d;
  logic           oe_q,   oe_d;
  logic           wr_en;

  // Next-state logic
  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    oe_d  = oe_q;
    wr_en = 1'b0;
    if (!act_i) begin
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      if (sclk_rise_i && (cnt_q < C_FRM)) begin
        rx_d  = {rx_q[RXW-2:0], sdi_i};
        cnt_d = cnt_q + 1'b1;
        if ((cnt_q == C_LAST) && (dir_e'(rx_q[RXW-1]) == DIR_WRITE)) wr_en = 1'b1;
      end
      if (sclk_fall_i) begin
        if ((cnt_q == C_HDR) && (dir_e'(rx_q[AW]) == DIR_READ)) begin
          oe_d = 1'b1;
          tx_d = rd_data_i;
        end else if (oe_q && (cnt_q > C_HDR) && (cnt_q < C_FRM)) begin
          tx_d = {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
      oe_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      oe_q  <= oe_d;
    end
  end

  assign rd_addr_o = rx_q[AW-1:0];
  assign wr_en_o   = wr_en;
  assign wr_addr_o = rx_q[RXW-2 -: AW];
  assign wr_data_o = {rx_q[DW-2:0], sdi_i};
  assign sdo_o     = tx_q[DW-1];
  assign oe_o      = oe_q;

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> !oe_q) else $error("output enable held outside frame"); // R6

  AST_OE_AT_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> ($past(sclk_fall_i) && ($past(cnt_q) == C_HDR))) else $error("turnaround at wrong edge"); // R5

  AST_TX_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !sclk_fall_i) |=> $stable(tx_q)) else $error("read data moved off a falling edge"); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= C_FRM) else $error("bit counter overran frame"); // R2

  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (act_i && !oe_q)) else $error("write strobe outside write frame"); // R7

endmodule

// File: rtl/spi3w_regslave.sv
// Top level: reset synchroniser, input resynchronisation, frame logic, registers.
module spi3w_regslave #(
  parameter int NREG        = 48,
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en_n,
  input  logic               csb,
  input  logic               sclk,
  input  logic               sdio_in,
  output logic               sdio_out,
  output logic               sdio_oe,
  output logic [NREG*DW-1:0] cfg_regs
);

  localparam int NIN   = 4;
  localparam int B_EN  = 3;
  localparam int B_CSB = 2;
  localparam int B_CLK = 1;
  localparam int B_DAT = 0;

  // Asynchronous assertion, synchronous release of the reset.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NIN-1:0] pins, pins_s, pins_rise, pins_fall;
  assign pins = {bus_en_n, csb, sclk, sdio_in};

  spi3w_insync #(
    .W       (NIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1100)
  ) i_insync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .d_i    (pins),
    .q_o    (pins_s),
    .rise_o (pins_rise),
    .fall_o (pins_fall)
  );

  logic          act;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en;

  assign act = !pins_s[B_EN] && !pins_s[B_CSB];

  spi3w_frame #(
    .AW (AW),
    .DW (DW)
  ) i_frame (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .act_i       (act),
    .sclk_rise_i (pins_rise[B_CLK]),
    .sclk_fall_i (pins_fall[B_CLK]),
    .sdi_i       (pins_s[B_DAT]),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .sdo_o       (sdio_out),
    .oe_o        (sdio_oe)
  );

  spi3w_regfile #(
    .NREG (NREG),
    .AW   (AW),
    .DW   (DW)
  ) i_regfile (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (cfg_regs)
  );

  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pins_s[B_EN] |=> $stable(cfg_regs)) else $error("register written while disabled"); // R1

  AST_DISABLED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(pins_s[B_EN]) |-> !sdio_oe) else $error("line driven while disabled"); // R1

endmodule

// File: tb/test_spi3w_regslave.sv
module test_spi3w_regslave;

  localparam int NREG = 48;
  localparam int AW   = 7;
  localparam int DW   = 8;
  localparam int HP   = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_en_n, csb, sclk, sdio_in;
  logic sdio_out, sdio_oe;
  logic [NREG*DW-1:0] cfg_regs;

  always #4 clk = ~clk;

  spi3w_regslave #(.NREG(NREG), .AW(AW), .DW(DW), .SYNC_STAGES(2)) i_spi3w_regslave (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en_n (bus_en_n),
    .csb      (csb),
    .sclk     (sclk),
    .sdio_in  (sdio_in),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe),
    .cfg_regs (cfg_regs)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [DW-1:0] model [NREG];

  function automatic logic [DW-1:0] exp_read(int a);
    return (a < NREG) ? model[a] : '0;
  endfunction

  function automatic logic [NREG*DW-1:0] exp_image();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = model[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bus frame. nbits rising edges are issued; en selects the enable level.
  task automatic xfer(input bit rw, input int addr, input logic [DW-1:0] wd,
                      input int nbits, input bit en);
    logic [15:0]   frame;
    logic [DW-1:0] rd;
    logic [DW-1:0] exp;
    bit            oe_bad;
    bit            oe_miss;
    bit            full;
    frame   = {rw, addr[AW-1:0], wd};
    exp     = exp_read(addr);
    rd      = '0;
    oe_bad  = 1'b0;
    oe_miss = 1'b0;
    full    = (nbits >= 16);
    bus_en_n = !en;
    idle(2);
    csb = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (i < 16 && !(rw && i >= 8)) sdio_in = frame[15-i];
      else                           sdio_in = 1'($urandom);
      idle(HP);
      sclk = 1'b1;
      if (en && rw && i >= 8 && i < 16) begin
        rd = {rd[DW-2:0], sdio_out};
        if (!sdio_oe) oe_miss = 1'b1;
      end else if (i < 16 && sdio_oe) begin
        oe_bad = 1'b1;
      end
      idle(HP);
      sclk = 1'b0;
    end
    idle(HP);
    csb = 1'b1;
    idle(HP);
    // R6: enable released after frame; low in header and write phases; R1 when disabled
    check(!oe_bad, en ? "R6" : "R1", "oe during header/write/disabled", 64'(oe_bad), 64'(0));
    check(!sdio_oe, "R6", "oe after csb high", 64'(sdio_oe), 64'(0));
    if (en && rw && full) begin
      check(!oe_miss, "R5", "oe during read data", 64'(oe_miss), 64'(0));
      check(rd == exp, (addr < NREG) ? "R5" : "R8", "read data", 64'(rd), 64'(exp));
    end
    if (en && !rw && full && addr < NREG) model[addr] = wd;
    // R4/R7/R8/R1/R2: full image compared with model
    check(cfg_regs == exp_image(), "R4", "register image", 64'(cfg_regs ^ exp_image()), 64'(0));
    bus_en_n = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    rst_n = 1'b0; bus_en_n = 1'b1; csb = 1'b1; sclk = 1'b0; sdio_in = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    // R9: reset state
    check(cfg_regs == '0, "R9", "regs after reset", 64'(cfg_regs[63:0]), 64'(0));
    check(!sdio_oe, "R9", "oe after reset", 64'(sdio_oe), 64'(0));
    bus_en_n = 1'b0;
    idle(4);

    // R3/R4: bit order, address 0x12 (reversed 0x24 also legal), data 0x80 / 0x01
    xfer(1'b0, 'h12, 8'h80, 16, 1'b1);
    xfer(1'b0, 'h24, 8'h01, 16, 1'b1);
    xfer(1'b1, 'h12, 8'h00, 16, 1'b1);   // R3 R5
    xfer(1'b1, 'h24, 8'h00, 16, 1'b1);
    // Boundaries of the file, R8
    xfer(1'b0, 'h00, 8'hA5, 16, 1'b1);
    xfer(1'b0, 'h2F, 8'h3C, 16, 1'b1);
    xfer(1'b1, 'h2F, 8'h00, 16, 1'b1);
    xfer(1'b0, 'h30, 8'hFF, 16, 1'b1);   // R8 ignored write
    xfer(1'b1, 'h30, 8'h00, 16, 1'b1);   // R8 reads zero
    xfer(1'b1, 'h7F, 8'h00, 16, 1'b1);
    // R7: write one edge short
    xfer(1'b0, 'h05, 8'h77, 15, 1'b1);
    xfer(1'b1, 'h05, 8'h00, 16, 1'b1);
    // R2: surplus clocks after a write
    xfer(1'b0, 'h06, 8'h5A, 18, 1'b1);
    xfer(1'b1, 'h06, 8'h00, 16, 1'b1);
    // R1: full frames while disabled
    xfer(1'b0, 'h07, 8'hC3, 16, 1'b0);
    xfer(1'b1, 'h00, 8'h00, 16, 1'b0);
    xfer(1'b1, 'h07, 8'h00, 16, 1'b1);

    // Random mix
    for (int n = 0; n < 240; n++) begin
      int  sel;
      int  a;
      int  nb;
      bit  r;
      bit  e;
      sel = int'($urandom_range(0, 99));
      a   = (sel < 80) ? int'($urandom_range(0, NREG-1)) : int'($urandom_range(0, 127));
      r   = 1'($urandom);
      e   = (sel % 10) != 3;
      nb  = (sel % 7 == 0) ? int'($urandom_range(1, 15)) : int'($urandom_range(16, 17));
      xfer(r, a, 8'($urandom), nb, e);
    end

    summary();
    $finish;
  end

endmodule